// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim/Complete

This block collects a parameterised number of level-sensitive device interrupt lines. It routes them to several target contexts, typically one per hart privilege level. Each source has a programmable priority. Each context owns an enable bitmap, a priority threshold and a claim/complete register. The block drives one request line per context. Software reaches every register over a plain word-wide register bus: an address, a write strobe, a read strobe, write data and combinational read data.

A gateway per source turns a high input into a pending bit. It then stops forwarding further requests from that source until software signals completion. A read of a context's claim register returns the best eligible source. In the same access it moves that source from pending to in service. Writing the same ID back re-arms the gateway, so no separate mask or unmask path is needed. ID 0 never names a source; a claim that returns 0 means nothing is eligible.

Top module: `plat_intc`

## Requirements
- R1: After reset, every priority, enable bit and threshold reads 0, no source is pending or in service, `irq_o` is all low and every claim register reads 0.
- R2: The priority of source N (1..NUM_SRC) sits at byte address 4*N. It stores the low PRIO_W bits of a write and reads back zero-extended. The entry at address 0 always reads 0 and ignores writes.
- R3: The enable bit of source N for context c is bit N%32 of the word at 0x2000 + 0x80*c + 4*(N/32). The bit for ID 0 always reads 0.
- R4: The threshold of context c is at 0x200000 + 0x1000*c. Its claim/complete register is at that address plus 4.
- R5: A source is eligible for context c only when it is pending, enabled for c, and its priority is strictly greater than c's threshold. `irq_o[c]` is high exactly when c has an eligible source.
- R6: A claim read (`re_i` high, `we_i` low) returns the eligible source with the highest priority, the lowest ID among equals, or 0 if there is none. At that clock edge it clears the source's pending bit and marks it in service. `irq_o[c]` falls in the next cycle if no other source is eligible.
- R7: A source whose input is high becomes pending at the next clock edge. While it is in service it does not become pending again, even if its input stays high.
- R8: A write of a source's ID to a claim register ends its service at that edge. If the input is still high, the source is pending again one edge later.
- R9: A completion write whose ID is not in service, or is not enabled for the addressed context, changes nothing.
- R10: Reads of misaligned or unimplemented addresses return 0. Writes to them change no state. Unimplemented addresses include source IDs above NUM_SRC, contexts at or above NUM_CTX, enable words past the last source, and context offsets other than 0 and 4.
- R11: Pending and in-service state is per source, shared by all contexts. A claim through one context removes the source from every context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level interrupt inputs; bit N is source N (1-based) |
| addr_i | input | 26 | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; enables the claim side effect |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | NUM_CTX | Interrupt request per context |

## Verification
The bench builds the block with its defaults: 40 sources, 2 contexts and 3-bit priorities. With 40 sources the enable map spans two words, so the word and bit split of the enable address is exercised. That includes a source above 31 that is shared by both contexts. With two contexts the bench can show a claim through one context hiding the source from the other, and a completion rejected because the context does not enable the source. A priority field of 3 bits makes ties and upper-bit truncation frequent under random writes.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int ADDR_W = 26;
  localparam logic [ADDR_W-1:0] PRIO_END = 26'h1000;
  localparam logic [ADDR_W-1:0] EN_BASE  = 26'h2000;
  localparam logic [ADDR_W-1:0] CTX_BASE = 26'h200000;
  localparam int EN_STRIDE_LG  = 7;
  localparam int CTX_STRIDE_LG = 12;
  typedef enum logic [2:0] {RG_NONE, RG_PRIO, RG_EN, RG_THR, RG_CLAIM} reg_kind_e;
endpackage

// File: rtl/intc_gateway.sv
`timescale 1ns/1ps
module intc_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic busy_o
);
  logic pending_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      pending_q <= claim_i ? 1'b0 : (pending_q | (req_i & ~busy_q));
      busy_q    <= claim_i ? 1'b1 : (complete_i ? 1'b0 : busy_q);
    end
  end

  assign pending_o = pending_q;
  assign busy_o    = busy_q;

  // R7
  no_repend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pending_q && busy_q));
  // R6
  busy_from_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(claim_i));
  // R8
  release_from_complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(complete_i));
endmodule

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter #(
  parameter int NUM_SRC = 40,
  parameter int PRIO_W  = 3,
  parameter int IDW     = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC:0]               elig_i,
  input  logic [NUM_SRC:0][PRIO_W-1:0]   prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic [IDW-1:0]                 id_o,
  output logic                           irq_o
);
  logic [PRIO_W-1:0] best_p;

  // strict compare keeps the lowest ID on a tie
  always_comb begin
    id_o   = '0;
    best_p = thr_i;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (elig_i[i] && prio_i[i] > best_p) begin
        id_o   = IDW'(i);
        best_p = prio_i[i];
      end
    end
  end

  assign irq_o = (id_o != '0);

  // R5
  winner_above_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (elig_i[id_o] && (prio_i[id_o] > thr_i)));
endmodule

// File: rtl/plat_intc.sv
`timescale 1ns/1ps
module plat_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC:1]    src_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_CTX-1:0]  irq_o
);
  localparam int IDW      = $clog2(NUM_SRC + 1);
  localparam int EN_WORDS = (NUM_SRC + 32) / 32;
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

  // ---------------- address decode ----------------
  reg_kind_e          kind;
  logic [ADDR_W-1:0]  en_off, ctx_off, ctx_full;
  logic [9:0]         dec_sid;
  logic [4:0]         dec_word;
  logic [CTX_W-1:0]   dec_ctx;

  assign en_off   = addr_i - EN_BASE;
  assign ctx_off  = addr_i - CTX_BASE;
  assign dec_sid  = addr_i[11:2];
  assign dec_word = en_off[6:2];

  always_comb begin
    kind     = RG_NONE;
    ctx_full = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i < PRIO_END) begin
        if (dec_sid <= 10'(NUM_SRC)) kind = RG_PRIO;
      end else if (addr_i >= EN_BASE && addr_i < CTX_BASE) begin
        ctx_full = en_off >> EN_STRIDE_LG;
        if (ctx_full < ADDR_W'(NUM_CTX) && dec_word < 5'(EN_WORDS)) kind = RG_EN;
      end else if (addr_i >= CTX_BASE) begin
        ctx_full = ctx_off >> CTX_STRIDE_LG;
        if (ctx_full < ADDR_W'(NUM_CTX)) begin
          if (ctx_off[11:0] == 12'h0)      kind = RG_THR;
          else if (ctx_off[11:0] == 12'h4) kind = RG_CLAIM;
        end
      end
    end
  end
  assign dec_ctx = ctx_full[CTX_W-1:0];

  // ---------------- state ----------------
  logic [NUM_SRC:0][PRIO_W-1:0]  prio_q;
  logic [NUM_CTX-1:0][NUM_SRC:0] en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
  logic [NUM_SRC:0] pending, busy, claim_vec, complete_vec;
  logic [NUM_CTX-1:0][IDW-1:0] best_id;

  logic [IDW-1:0]    sel_id;
  logic [NUM_SRC:0]  sel_en;
  logic [PRIO_W-1:0] sel_thr;
  logic claim_rd, cmp_wr;

  always_comb begin
    sel_id  = '0;
    sel_en  = '0;
    sel_thr = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (dec_ctx == CTX_W'(c)) begin
        sel_id  = best_id[c];
        sel_en  = en_q[c];
        sel_thr = thr_q[c];
      end
    end
  end

  assign claim_rd = re_i && !we_i && (kind == RG_CLAIM);
  assign cmp_wr   = we_i && (kind == RG_CLAIM);

  always_comb begin
    claim_vec    = '0;
    complete_vec = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      claim_vec[i]    = claim_rd && (sel_id == IDW'(i));
      complete_vec[i] = cmp_wr && (wdata_i == 32'(i)) && busy[i] && sel_en[i];
    end
  end

  // ---------------- gateways ----------------
  assign pending[0] = 1'b0;
  assign busy[0]    = 1'b0;
  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_gw
    intc_gateway u_gw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (src_i[g]),
      .claim_i    (claim_vec[g]),
      .complete_i (complete_vec[g]),
      .pending_o  (pending[g]),
      .busy_o     (busy[g])
    );
  end

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (we_i) begin
      for (int i = 1; i <= NUM_SRC; i++)
        if (kind == RG_PRIO && dec_sid == 10'(i)) prio_q[i] <= wdata_i[PRIO_W-1:0];
      for (int c = 0; c < NUM_CTX; c++) begin
        if (dec_ctx == CTX_W'(c)) begin
          if (kind == RG_THR) thr_q[c] <= wdata_i[PRIO_W-1:0];
          for (int i = 1; i <= NUM_SRC; i++)
            if (kind == RG_EN && dec_word == 5'(i / 32)) en_q[c][i] <= wdata_i[i % 32];
        end
      end
    end
  end

  // ---------------- per-context arbitration ----------------
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .elig_i (pending & en_q[c]),
      .prio_i (prio_q),
      .thr_i  (thr_q[c]),
      .id_o   (best_id[c]),
      .irq_o  (irq_o[c])
    );
  end

  // ---------------- read mux ----------------
  always_comb begin
    rdata_o = '0;
    unique case (kind)
      RG_PRIO: for (int i = 1; i <= NUM_SRC; i++)
                 if (dec_sid == 10'(i)) rdata_o[PRIO_W-1:0] = prio_q[i];
      RG_EN:   for (int i = 1; i <= NUM_SRC; i++)
                 if (dec_word == 5'(i / 32)) rdata_o[i % 32] = sel_en[i];
      RG_THR:   rdata_o[PRIO_W-1:0] = sel_thr;
      RG_CLAIM: rdata_o[IDW-1:0]    = sel_id;
      default:  rdata_o = '0;
    endcase
  end

  // R6 R11
  claim_clears_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_rd && sel_id != '0) |=> !pending[$past(sel_id)]);
  // R9
  write_keeps_service_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !(|complete_vec)) |=> $stable(busy));
endmodule

// File: tb/sim_plat_intc.sv
`timescale 1ns/1ps
module sim_plat_intc;
  localparam int NS  = 40;
  localparam int NC  = 2;
  localparam int PW  = 3;
  localparam int EWN = (NS + 32) / 32;
  localparam int PMASK = (1 << PW) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NS:1] src_i = '0;
  logic [25:0] addr_i = '0;
  logic we_i = 1'b0, re_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NC-1:0] irq_o;

  plat_intc #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(PW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .addr_i(addr_i), .we_i(we_i),
    .re_i(re_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o));

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [NS:1] src_v = '0;
  logic [31:0] last_rd;
  logic [NC-1:0] last_irq;

  // bench model
  int m_prio [0:NS];
  bit m_en [0:NC-1][0:NS];
  int m_thr [0:NC-1];
  bit m_pend [0:NS];
  bit m_busy [0:NS];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void m_dec(input logic [25:0] a, output int kind, output int c, output int idx);
    int ai;
    ai = int'(a);
    kind = 0; c = 0; idx = 0;
    if (a[1:0] != 2'b00) return;
    if (ai < 'h1000) begin
      idx = ai / 4;
      if (idx <= NS) kind = 1;
    end else if (ai >= 'h2000 && ai < 'h200000) begin
      c = (ai - 'h2000) / 'h80;
      idx = ((ai - 'h2000) % 'h80) / 4;
      if (c < NC && idx < EWN) kind = 2;
    end else if (ai >= 'h200000) begin
      c = (ai - 'h200000) / 'h1000;
      idx = (ai - 'h200000) % 'h1000;
      if (c < NC) begin
        if (idx == 0) kind = 3;
        else if (idx == 4) kind = 4;
      end
    end
  endfunction

  function automatic int m_best(int c);
    int b = 0;
    int bp = m_thr[c];
    for (int i = 1; i <= NS; i++)
      if (m_pend[i] && m_en[c][i] && m_prio[i] > bp) begin b = i; bp = m_prio[i]; end
    return b;
  endfunction

  function automatic logic [31:0] m_read(logic [25:0] a);
    int k, c, x;
    logic [31:0] r = '0;
    m_dec(a, k, c, x);
    case (k)
      1: r = (x >= 1) ? 32'(m_prio[x]) : 32'd0;
      2: for (int b = 0; b < 32; b++) begin
           int n = x * 32 + b;
           if (n >= 1 && n <= NS && m_en[c][n]) r[b] = 1'b1;
         end
      3: r = 32'(m_thr[c]);
      4: r = 32'(m_best(c));
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [NC-1:0] m_irq();
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = (m_best(c) != 0);
    return v;
  endfunction

  function automatic void m_edge(bit we, bit re, logic [25:0] a, logic [31:0] wd);
    int k, c, x, cl, cp;
    m_dec(a, k, c, x);
    cl = 0; cp = 0;
    if (!we && re && k == 4) cl = m_best(c);
    if (we && k == 4 && wd >= 1 && wd <= NS && m_busy[wd] && m_en[c][wd]) cp = int'(wd);
    for (int i = 1; i <= NS; i++) begin
      bit np, nb;
      np = (i == cl) ? 1'b0 : (m_pend[i] | (src_v[i] & ~m_busy[i]));
      nb = (i == cl) ? 1'b1 : ((i == cp) ? 1'b0 : m_busy[i]);
      m_pend[i] = np;
      m_busy[i] = nb;
    end
    if (we) begin
      if (k == 1 && x >= 1) m_prio[x] = int'(wd) & PMASK;
      if (k == 2)
        for (int b = 0; b < 32; b++) begin
          int n = x * 32 + b;
          if (n >= 1 && n <= NS) m_en[c][n] = wd[b];
        end
      if (k == 3) m_thr[c] = int'(wd) & PMASK;
    end
  endfunction

  task automatic step(bit we, bit re, logic [25:0] a, logic [31:0] wd, string tag);
    @(negedge clk_i);
    src_i = src_v; we_i = we; re_i = re; addr_i = a; wdata_i = wd;
    #1;
    last_rd  = rdata_o;
    last_irq = irq_o;
    if (re) chk(tag, rdata_o, m_read(a));
    chk("R5 irq", 32'(irq_o), 32'(m_irq()));
    @(posedge clk_i);
    m_edge(we, re, a, wd);
  endtask

  task automatic wr(logic [25:0] a, logic [31:0] d, string tag);
    step(1'b1, 1'b0, a, d, tag);
  endtask
  task automatic idle();
    step(1'b0, 1'b0, 26'h0, 32'h0, "R7 idle");
  endtask
  task automatic rd_exp(logic [25:0] a, logic [31:0] e, string tag);
    step(1'b0, 1'b1, a, 32'h0, tag);
    chk(tag, last_rd, e);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i <= NS; i++) begin m_prio[i] = 0; m_pend[i] = 0; m_busy[i] = 0; end
    for (int c = 0; c < NC; c++) begin
      m_thr[c] = 0;
      for (int i = 0; i <= NS; i++) m_en[c][i] = 0;
    end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    rd_exp(26'h4, 0, "R1 prio");
    rd_exp(26'h200004, 0, "R1 claim");
    rd_exp(26'h2000, 0, "R1 enable");
    chk("R1 irq", 32'(last_irq), 0);

    // R2 priority map
    wr(26'h14, 32'hFFFF_FFFF, "R2");
    rd_exp(26'h14, 7, "R2 truncate");
    wr(26'h0, 3, "R2");
    rd_exp(26'h0, 0, "R2 id0");

    // R3 enable map: source 33 -> word 1 bit 1
    wr(26'h2084, 2, "R3");
    rd_exp(26'h2084, 2, "R3 ctx1 word1");
    wr(26'h2000, 1, "R3");
    rd_exp(26'h2000, 0, "R3 bit0");
    wr(26'h2004, 2, "R3");

    // R11 shared source across contexts
    wr(26'h84, 4, "R2");
    src_v[33] = 1'b1;
    idle(); idle();
    chk("R11 both irq", 32'(last_irq), 3);
    rd_exp(26'h201004, 33, "R11 claim ctx1");
    idle();
    chk("R6 irq drop", 32'(last_irq), 0);
    rd_exp(26'h200004, 0, "R11 hidden from ctx0");
    wr(26'h201004, 33, "R8");
    idle(); idle();
    rd_exp(26'h200004, 33, "R8 rearm");
    src_v[33] = 1'b0;
    wr(26'h200004, 33, "R8");
    wr(26'h2004, 0, "R3");
    wr(26'h2084, 0, "R3");

    // R4 R5 R6 R7 arbitration and threshold
    wr(26'hC, 2, "R2");
    wr(26'h1C, 2, "R2");
    wr(26'h24, 1, "R2");
    wr(26'h2000, 32'h288, "R3");
    wr(26'h200000, 1, "R4");
    rd_exp(26'h200000, 1, "R4 thr");
    src_v[3] = 1'b1; src_v[7] = 1'b1; src_v[9] = 1'b1;
    idle(); idle();
    chk("R5 irq ctx0", 32'(last_irq[0]), 1);
    rd_exp(26'h200004, 3, "R6 tie lowest id");
    rd_exp(26'h200004, 7, "R6 second");
    rd_exp(26'h200004, 0, "R5 prio not above thr");
    idle();
    chk("R6 irq drop", 32'(last_irq[0]), 0);
    idle(); idle();
    rd_exp(26'h200004, 0, "R7 no repend while claimed");
    wr(26'h200004, 3, "R8");
    idle(); idle();
    rd_exp(26'h200004, 3, "R8 rearm");

    // R9 ignored completions
    wr(26'h201004, 7, "R9");
    wr(26'h200004, 9, "R9");
    wr(26'h200000, 0, "R4");
    idle();
    rd_exp(26'h200004, 9, "R9 ignored complete");
    wr(26'h200004, 7, "R8");
    idle(); idle();
    rd_exp(26'h200004, 7, "R8 rearm after valid complete");

    // R10 unimplemented space
    rd_exp(26'h1004, 0, "R10 gap");
    rd_exp(26'h0D, 0, "R10 misaligned");
    rd_exp(26'hA4, 0, "R10 src beyond count");
    rd_exp(26'h202000, 0, "R10 ctx beyond count");
    rd_exp(26'h200008, 0, "R10 ctx offset");
    rd_exp(26'h2008, 0, "R10 enable word");
    wr(26'h202000, 5, "R10");
    wr(26'h1000, 5, "R10");
    wr(26'h0E, 7, "R10");
    rd_exp(26'h201000, 0, "R10 thr untouched");
    rd_exp(26'hC, 2, "R10 prio untouched");

    // random phase
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 99));
      if ($urandom_range(0, 3) == 0) begin
        int b;
        b = int'($urandom_range(1, NS));
        src_v[b] = ~src_v[b];
      end
      if (op < 20)
        wr(26'(4 * $urandom_range(0, NS + 2)), $urandom, "R2 rand");
      else if (op < 32)
        wr(26'('h2000 + 'h80 * $urandom_range(0, NC) + 4 * $urandom_range(0, 2)), $urandom, "R3 rand");
      else if (op < 40)
        wr(26'('h200000 + 'h1000 * $urandom_range(0, NC - 1)), 32'($urandom_range(0, 4)), "R4 rand");
      else if (op < 65)
        step(1'b0, 1'b1, 26'('h200004 + 'h1000 * $urandom_range(0, NC - 1)), 0, "R6 rand claim");
      else if (op < 85)
        wr(26'('h200004 + 'h1000 * $urandom_range(0, NC - 1)), 32'($urandom_range(0, NS + 1)), "R9 rand complete");
      else if (op < 92)
        step(1'b0, 1'b1, 26'(4 * $urandom_range(0, NS + 2)), 0, "R2 rand read");
      else
        idle();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule